// File: doc/BRIEF.md
# Host-to-Service-Processor Command Mailbox

This block is a small memory-mapped register file. A host on one side hands commands to a service processor on the other side. The host fills two pointer words and up to sixteen payload bytes, then writes a command word. That command word carries an opcode, a subcommand, a payload byte count and a flag that asks for an interrupt when the command completes. Writing the command word makes the block busy and sends a one-cycle doorbell to the responder. While the command is outstanding, the responder sees the decoded fields, the pointers and the payload. Any payload bytes past the declared count are forced to zero.

The responder finishes a command with a done strobe that carries an error flag, an error-code byte and up to four response words. The block then drops busy, latches the result into the status word and the read buffer, and raises a sticky interrupt if the command asked for one. The host clears that interrupt by writing 1 to its status bit.

The error-code byte passes through unchanged, and the host interprets it:

| Code | Meaning |
|------|---------|
| 0 | success |
| 1 | unsupported |
| 2 | not serviced |
| 3 | cannot service |
| 4 | invalid command |
| 5 | failure |
| 6 | security violation |
| 7 | unsigned image |

Host reads are combinational from `hst_addr`. Host writes take effect at the rising clock edge on which `hst_wr_en` is high.

Top module: `ipc_mbox`

## Requirements
- R1: After reset every host-readable register reads 0, and `irq` and `rsp_doorbell` are low.
- R2: Writing offset 0x00 while idle has three effects. From the next cycle, status bit 0 (busy) reads 1. `rsp_doorbell` is high for exactly that one cycle. `rsp_cmd`, `rsp_sub` and `rsp_len` present command-word bits 7:0, 15:12 and 20:16, and offset 0x00 reads back the whole word.
- R3: A write to offset 0x00 while busy is ignored: there is no doorbell, and neither the command readback nor the responder fields change.
- R4: `rsp_done` while busy clears busy in the next cycle. It also latches `rsp_err` into status bit 1 and `rsp_code` into status bits 23:16. `rsp_done` while idle has no effect.
- R5: The next accepted command write clears the error bit and the error-code byte to 0.
- R6: When command-word bit 8 was set, the completing `rsp_done` sets status bit 2 (pending) and `irq`. Both stay high until cleared. When bit 8 was clear, completion leaves both low.
- R7: A status write with bit 2 set clears pending, and one with bit 2 clear leaves it alone. Status writes never change busy, error or the code byte. If done and a clearing write land in the same cycle, pending ends up set.
- R8: Offset 0x08 (source pointer) and offset 0x0C (destination pointer) are read/write and drive `rsp_sptr` and `rsp_dptr`.
- R9: The four words at 0x80, 0x84, 0x88 and 0x8C are read/write payload. `rsp_payload` byte k (bits 8k+7:8k) is payload word k/4, byte k%4, counting little-endian. That byte is shown only when k is below the length field; otherwise it is 0. A length above 16 counts as 16.
- R10: Writes to the pointer and payload registers while busy are ignored.
- R11: Offsets 0x90 through 0x9C read the response words; word i is `rsp_data` bits 32i+31:32i, captured on an accepted done. Host writes there are ignored, and unmapped or misaligned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host write strobe |
| hst_addr | input | 8 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` |
| rsp_doorbell | output | 1 | One-cycle pulse per accepted command |
| rsp_cmd | output | 8 | Command opcode |
| rsp_sub | output | 4 | Subcommand |
| rsp_len | output | 5 | Payload length in bytes |
| rsp_sptr | output | 32 | Source pointer |
| rsp_dptr | output | 32 | Destination pointer |
| rsp_payload | output | 128 | Length-masked payload |
| rsp_done | input | 1 | Responder completion strobe |
| rsp_err | input | 1 | Error flag qualified by `rsp_done` |
| rsp_code | input | 8 | Error code qualified by `rsp_done` |
| rsp_data | input | 128 | Response words qualified by `rsp_done` |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions rely on two things about the inputs. First, the responder signals `rsp_done` only as a single-cycle strobe. Second, the host issues at most one write per cycle, so no single write can target the command and status registers together. The bench drives every input on the falling edge and holds done for exactly one cycle. It also creates the deliberate overlaps on purpose: a command written while busy, done while idle, and done in the same cycle as an interrupt clear. The assertions therefore see legal but awkward timing rather than only the quiet cases.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  // Register offsets (byte addresses)
  localparam int OFS_CMD  = 'h00;
  localparam int OFS_STS  = 'h04;
  localparam int OFS_SPTR = 'h08;
  localparam int OFS_DPTR = 'h0C;
  localparam int OFS_WBUF = 'h80;

  // Command word fields
  localparam int CF_OP_LSB  = 0;
  localparam int CF_IRQ_BIT = 8;
  localparam int CF_SUB_LSB = 12;
  localparam int CF_LEN_LSB = 16;

  // Status word fields
  localparam int ST_BUSY     = 0;
  localparam int ST_ERR      = 1;
  localparam int ST_PEND     = 2;
  localparam int ST_CODE_LSB = 16;

  // Result codes returned by the responder (passed through untouched)
  typedef enum logic [7:0] {
    RC_OK           = 8'd0,
    RC_UNSUPPORTED  = 8'd1,
    RC_NOT_SERVICED = 8'd2,
    RC_NO_RESOURCE  = 8'd3,
    RC_BAD_CMD      = 8'd4,
    RC_FAILED       = 8'd5,
    RC_SECURITY     = 8'd6,
    RC_UNSIGNED     = 8'd7
  } ipc_rc_e;

  function automatic logic [31:0] sts_pack(input logic busy, input logic err,
                                           input logic pend, input logic [7:0] code);
    logic [31:0] w;
    w = '0;
    w[ST_BUSY] = busy;
    w[ST_ERR]  = err;
    w[ST_PEND] = pend;
    w[ST_CODE_LSB +: 8] = code;
    return w;
  endfunction
endpackage

// File: rtl/ipc_mbox_ctl.sv
module ipc_mbox_ctl
  import ipc_mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic        sts_wr,
  input  logic [31:0] wdata,
  input  logic        done_in,
  input  logic        err_in,
  input  logic [7:0]  code_in,
  output logic        busy,
  output logic        cmd_acc,
  output logic        done_acc,
  output logic [31:0] cmd_word,
  output logic        err_q,
  output logic [7:0]  code_q,
  output logic        pend,
  output logic        doorbell
);
  logic pend_clr;
  logic pend_set;

  // Named events for the assertions and the rest of the block
  assign cmd_acc  = cmd_wr & ~busy;
  assign done_acc = done_in & busy;
  assign pend_clr = sts_wr & wdata[ST_PEND];
  assign pend_set = done_acc & cmd_word[CF_IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cmd_word <= '0;
      err_q    <= 1'b0;
      code_q   <= '0;
      doorbell <= 1'b0;
    end else begin
      doorbell <= cmd_acc;
      if (cmd_acc) begin
        busy     <= 1'b1;
        cmd_word <= wdata;
        err_q    <= 1'b0;
        code_q   <= '0;
      end else if (done_acc) begin
        busy   <= 1'b0;
        err_q  <= err_in;
        code_q <= code_in;
      end
    end
  end

  // Set has priority over a simultaneous write-1-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (pend_set) pend <= 1'b1;
    else if (pend_clr) pend <= 1'b0;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> (busy && doorbell)); // R2
  AST_DOORBELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell); // R2
  AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_word)); // R3
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_in) |=> busy); // R4
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> (!err_q && code_q == 8'h00)); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !sts_wr) |=> pend); // R6
  AST_PEND_ONLY_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(done_acc && cmd_word[CF_IRQ_BIT])); // R6
  AST_STS_WRITE_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !done_in) |=> ($stable(err_q) && $stable(code_q))); // R7
endmodule

// File: rtl/ipc_mbox_buf.sv
module ipc_mbox_buf
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 4,
  localparam int PL_W  = NWORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              lock,
  input  logic              cap,
  input  logic [PL_W-1:0]   cap_data,
  output logic [31:0]       sptr,
  output logic [31:0]       dptr,
  output logic [PL_W-1:0]   wbuf,
  output logic [PL_W-1:0]   rbuf
);
  localparam logic [ADDR_W-1:0] A_SPTR = ADDR_W'(OFS_SPTR);
  localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'(OFS_DPTR);

  logic host_ok;
  assign host_ok = wr_en & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sptr <= '0;
      dptr <= '0;
    end else if (host_ok) begin
      if (addr == A_SPTR) sptr <= wdata;
      if (addr == A_DPTR) dptr <= wdata;
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [ADDR_W-1:0] A_W = ADDR_W'(OFS_WBUF + 4 * i);
    logic wsel;
    assign wsel = host_ok && (addr == A_W);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wbuf[32*i +: 32] <= '0;
      else if (wsel) wbuf[32*i +: 32] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rbuf[32*i +: 32] <= '0;
      else if (cap) rbuf[32*i +: 32] <= cap_data[32*i +: 32];
    end
  end

  AST_WBUF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(wbuf) && $stable(sptr) && $stable(dptr))); // R10
  AST_RBUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(rbuf)); // R11
endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 4,
  localparam int PL_W     = NWORDS * 32,
  localparam int PL_BYTES = NWORDS * 4,
  localparam int OFS_RBUF = OFS_WBUF + PL_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr_en,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              rsp_doorbell,
  output logic [7:0]        rsp_cmd,
  output logic [3:0]        rsp_sub,
  output logic [4:0]        rsp_len,
  output logic [31:0]       rsp_sptr,
  output logic [31:0]       rsp_dptr,
  output logic [PL_W-1:0]   rsp_payload,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_code,
  input  logic [PL_W-1:0]   rsp_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_SPTR = ADDR_W'(OFS_SPTR);
  localparam logic [ADDR_W-1:0] A_DPTR = ADDR_W'(OFS_DPTR);

  // Payload bytes at or beyond the (clamped) length are presented as zero
  function automatic logic [PL_W-1:0] payload_mask(input logic [PL_W-1:0] d,
                                                   input logic [4:0] len);
    logic [PL_W-1:0] r;
    int lim;
    lim = (int'(len) > PL_BYTES) ? PL_BYTES : int'(len);
    for (int k = 0; k < PL_BYTES; k++)
      r[8*k +: 8] = (k < lim) ? d[8*k +: 8] : 8'h00;
    return r;
  endfunction

  logic            cmd_wr, sts_wr;
  logic            busy, cmd_acc, done_acc, err_q, pend;
  logic [31:0]     cmd_word;
  logic [7:0]      code_q;
  logic [PL_W-1:0] wbuf, rbuf;

  assign cmd_wr = hst_wr_en && (hst_addr == A_CMD);
  assign sts_wr = hst_wr_en && (hst_addr == A_STS);

  ipc_mbox_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .sts_wr   (sts_wr),
    .wdata    (hst_wdata),
    .done_in  (rsp_done),
    .err_in   (rsp_err),
    .code_in  (rsp_code),
    .busy     (busy),
    .cmd_acc  (cmd_acc),
    .done_acc (done_acc),
    .cmd_word (cmd_word),
    .err_q    (err_q),
    .code_q   (code_q),
    .pend     (pend),
    .doorbell (rsp_doorbell)
  );

  ipc_mbox_buf #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (hst_wr_en),
    .addr     (hst_addr),
    .wdata    (hst_wdata),
    .lock     (busy),
    .cap      (done_acc),
    .cap_data (rsp_data),
    .sptr     (rsp_sptr),
    .dptr     (rsp_dptr),
    .wbuf     (wbuf),
    .rbuf     (rbuf)
  );

  assign rsp_cmd     = cmd_word[CF_OP_LSB +: 8];
  assign rsp_sub     = cmd_word[CF_SUB_LSB +: 4];
  assign rsp_len     = cmd_word[CF_LEN_LSB +: 5];
  assign rsp_payload = payload_mask(wbuf, rsp_len);
  assign irq         = pend;

  always_comb begin
    hst_rdata = '0;
    if (hst_addr == A_CMD)  hst_rdata = cmd_word;
    if (hst_addr == A_STS)  hst_rdata = sts_pack(busy, err_q, pend, code_q);
    if (hst_addr == A_SPTR) hst_rdata = rsp_sptr;
    if (hst_addr == A_DPTR) hst_rdata = rsp_dptr;
    for (int i = 0; i < NWORDS; i++) begin
      if (hst_addr == ADDR_W'(OFS_WBUF + 4 * i)) hst_rdata = wbuf[32*i +: 32];
      if (hst_addr == ADDR_W'(OFS_RBUF + 4 * i)) hst_rdata = rbuf[32*i +: 32];
    end
  end

  AST_DOORBELL_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_acc) |=> ($stable(rsp_cmd) && $stable(rsp_sub) && $stable(rsp_len))); // R3
  AST_IRQ_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && cmd_word[CF_IRQ_BIT] && sts_wr) |=> irq); // R7
  AST_DONE_IDLE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !busy && !hst_wr_en) |=> ($stable(hst_rdata) && !busy)); // R4
endmodule

// File: tb/ipc_mbox_tb.sv
module ipc_mbox_tb_top;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hst_wr_en = 1'b0;
  logic [7:0]   hst_addr = '0;
  logic [31:0]  hst_wdata = '0;
  logic [31:0]  hst_rdata;
  logic         rsp_doorbell;
  logic [7:0]   rsp_cmd;
  logic [3:0]   rsp_sub;
  logic [4:0]   rsp_len;
  logic [31:0]  rsp_sptr, rsp_dptr;
  logic [127:0] rsp_payload;
  logic         rsp_done = 1'b0;
  logic         rsp_err = 1'b0;
  logic [7:0]   rsp_code = '0;
  logic [127:0] rsp_data = '0;
  logic         irq;

  int nvec = 0;
  int nbad = 0;
  bit over = 0;

  always #(CLK_P/2) clk = ~clk;

  ipc_mbox dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .rsp_doorbell(rsp_doorbell),
    .rsp_cmd(rsp_cmd), .rsp_sub(rsp_sub), .rsp_len(rsp_len),
    .rsp_sptr(rsp_sptr), .rsp_dptr(rsp_dptr), .rsp_payload(rsp_payload),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_code(rsp_code),
    .rsp_data(rsp_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  task automatic done(input logic e, input logic [7:0] c, input logic [127:0] dat);
    @(negedge clk);
    rsp_done = 1'b1; rsp_err = e; rsp_code = c; rsp_data = dat;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input int op, input int sub, input int len, input bit ie);
    return (32'(len) << 16) | (32'(sub) << 12) | (ie ? 32'h100 : 32'h0) | 32'(op);
  endfunction

  function automatic logic [31:0] mk_sts(input bit b, input bit e, input bit p, input int code);
    return (32'(code) << 16) | (p ? 32'd4 : 32'd0) | (e ? 32'd2 : 32'd0) | (b ? 32'd1 : 32'd0);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    foreach (v[i]) ; // no-op
    for (int a = 0; a < 'hA0; a += 4) begin
      rd(8'(a), v);
      chk("R1 reg read after reset", v, 0);
    end
    chk("R1 irq after reset", irq, 0);
    chk("R1 doorbell after reset", rsp_doorbell, 0);
  endtask

  task automatic t_simple();
    logic [31:0] v, c;
    c = mk_cmd('hEE, 5, 0, 0);
    wr(8'h00, c);
    chk("R2 doorbell pulse", rsp_doorbell, 1);
    chk("R2 opcode field", rsp_cmd, 8'hEE);
    chk("R2 sub field", rsp_sub, 4'd5);
    chk("R2 len field", rsp_len, 5'd0);
    rd(8'h04, v);
    chk("R2 busy set", v, mk_sts(1, 0, 0, 0));
    chk("R2 doorbell single cycle", rsp_doorbell, 0);
    rd(8'h00, v);
    chk("R2 cmd readback", v, c);
    done(0, 0, '0);
    rd(8'h04, v);
    chk("R4 busy cleared", v, mk_sts(0, 0, 0, 0));
    chk("R6 no irq without request", irq, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v, c;
    c = mk_cmd('hED, 1, 4, 0);
    wr(8'h08, 32'h1111_0000);
    wr(8'h80, 32'hAAAA_5555);
    wr(8'h00, c);
    wr(8'h00, mk_cmd('h12, 9, 8, 1));
    chk("R3 no doorbell when busy", rsp_doorbell, 0);
    chk("R3 opcode kept", rsp_cmd, 8'hED);
    rd(8'h00, v);
    chk("R3 cmd readback kept", v, c);
    wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h80, 32'h0BAD_0BAD);
    rd(8'h08, v);
    chk("R10 sptr locked while busy", v, 32'h1111_0000);
    rd(8'h80, v);
    chk("R10 wbuf locked while busy", v, 32'hAAAA_5555);
    done(0, 0, '0);
    rd(8'h04, v);
    chk("R6 ignored irq flag not used", irq, 0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    wr(8'h00, mk_cmd('hEC, 0, 0, 0));
    done(1, 7, '0);
    rd(8'h04, v);
    chk("R4 error latched code 7", v, mk_sts(0, 1, 0, 7));
    wr(8'h04, 32'h00FF_0003);
    rd(8'h04, v);
    chk("R7 status write keeps err", v, mk_sts(0, 1, 0, 7));
    done(0, 3, '0);
    rd(8'h04, v);
    chk("R4 done while idle ignored", v, mk_sts(0, 1, 0, 7));
    wr(8'h00, mk_cmd('hEB, 0, 0, 0));
    rd(8'h04, v);
    chk("R5 err cleared by new cmd", v, mk_sts(1, 0, 0, 0));
    done(1, 6, '0);
    rd(8'h04, v);
    chk("R4 security code", v, mk_sts(0, 1, 0, 6));
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h00, mk_cmd('hF0, 2, 0, 1));
    chk("R6 no irq before done", irq, 0);
    done(0, 0, '0);
    chk("R6 irq after done", irq, 1);
    repeat (3) @(negedge clk);
    chk("R6 irq sticky", irq, 1);
    wr(8'h04, 32'h0000_0003);
    chk("R7 bit2 clear write keeps pending", irq, 1);
    wr(8'h04, 32'h0000_0004);
    chk("R7 w1c clears pending", irq, 0);
    rd(8'h04, v);
    chk("R7 status after clear", v, mk_sts(0, 0, 0, 0));
    wr(8'h00, mk_cmd('hF0, 3, 0, 1));
    @(negedge clk);
    rsp_done = 1'b1; rsp_err = 0; rsp_code = 0;
    hst_wr_en = 1'b1; hst_addr = 8'h04; hst_wdata = 32'h4;
    @(negedge clk);
    rsp_done = 1'b0; hst_wr_en = 1'b0;
    chk("R7 set wins over clear", irq, 1);
    wr(8'h04, 32'h4);
    chk("R7 final clear", irq, 0);
  endtask

  task automatic t_ptrs();
    logic [31:0] v;
    wr(8'h08, 32'hCAFE_0008);
    wr(8'h0C, 32'hBEEF_000C);
    rd(8'h08, v);
    chk("R8 sptr readback", v, 32'hCAFE_0008);
    rd(8'h0C, v);
    chk("R8 dptr readback", v, 32'hBEEF_000C);
    chk("R8 sptr port", rsp_sptr, 32'hCAFE_0008);
    chk("R8 dptr port", rsp_dptr, 32'hBEEF_000C);
  endtask

  task automatic t_payload(input int len);
    logic [127:0] exp;
    logic [31:0] v;
    for (int w = 0; w < 4; w++)
      wr(8'('h80 + 4*w), {8'(16*w+4), 8'(16*w+3), 8'(16*w+2), 8'(16*w+1)});
    rd(8'h88, v);
    chk("R9 wbuf readback", v, 32'h2423_2221);
    wr(8'h00, mk_cmd('hFF, 1, len, 0));
    exp = '0;
    for (int b = 0; b < 16; b++)
      if (b < len) exp = exp | (128'(((b / 4) * 16) + (b % 4) + 1) << (8*b));
    chk($sformatf("R9 payload mask len %0d", len), rsp_payload, exp);
    done(0, 0, '0);
  endtask

  task automatic t_rbuf();
    logic [31:0] v;
    logic [127:0] d;
    d = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    wr(8'h00, mk_cmd('hEA, 0, 0, 0));
    done(0, 0, d);
    for (int i = 0; i < 4; i++) begin
      rd(8'('h90 + 4*i), v);
      chk("R11 response word", v, d[32*i +: 32]);
    end
    wr(8'h94, 32'h9999_9999);
    rd(8'h94, v);
    chk("R11 host write to rbuf ignored", v, 32'h2222_2222);
    done(0, 0, '1);
    rd(8'h90, v);
    chk("R11 done while idle no capture", v, 32'h1111_1111);
    rd(8'h06, v);
    chk("R11 misaligned reads zero", v, 0);
    rd(8'h40, v);
    chk("R11 unmapped reads zero", v, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!over) begin
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_simple();
    t_busy_ignore();
    t_error();
    t_irq();
    t_ptrs();
    t_payload(5);
    t_payload(0);
    t_payload(16);
    t_payload(31);
    t_rbuf();
    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule